// File: doc/BRIEF.md
# Machine-Cycle Clock Enable Generator

This block derives all of the timing strobes for an 8051-style processor core from a single oscillator clock. It issues single-cycle enable pulses that mark machine-cycle ends for the CPU and clock periods for seven peripherals: watchdog, counter array, UART, timer 2, timer 1, timer 0 and SPI. It also issues a free-running address-latch strobe. All outputs are enables in the oscillator clock domain. No derived clocks are produced.

A global double-speed bit halves the machine cycle from 12 to 6 oscillator periods. When that bit is set, each peripheral has its own override bit that returns it to 12 periods. When the global bit is clear, the override bits have no effect.

An 8-bit reload register inserts an optional prescaler in front of the machine-cycle divider. Every period listed below is counted in prescaled ticks. Control writes are held in a pending copy and become active only at the next machine-cycle boundary, so a pulse spacing never breaks part way through.

Top module: `mcg_top`

## Requirements
- R1: After reset the reload register is FFh, every per-peripheral bit is 0, and the global double-speed bit takes the value of `cfg_x2_boot` sampled during reset.
- R2: With the global bit clear, `cpu_en` and every bit of `per_en` pulse once per 12 ticks, whatever the per-peripheral bits hold.
- R3: With the global bit set, `cpu_en` pulses once per 6 ticks.
- R4: With the global bit set, a peripheral whose bit is 0 pulses every 6 ticks and one whose bit is 1 pulses every 12 ticks. Bit mapping: control 0 bit 0 is the global bit. Control 0 bits 6..1 drive `per_en[6]` (watchdog), `per_en[5]` (counter array), `per_en[4]` (UART), `per_en[3]` (timer 2), `per_en[2]` (timer 1) and `per_en[1]` (timer 0). Control 1 bit 0 drives `per_en[0]` (SPI).
- R5: `ale_stb` pulses every 6 ticks with the global bit clear and every 3 ticks with it set.
- R6: A reload value of FFh makes one tick per oscillator cycle. A value N below FFh makes one tick per 2×(255−N) oscillator cycles.
- R7: Control changes become active only at a machine-cycle boundary, which is the end of a 12-tick frame. Every enable is one cycle wide. Each interval between CPU pulses during a change equals the old period or the new one. Every `per_en` pulse coincides with a `cpu_en` pulse, and every `cpu_en` pulse coincides with an `ale_stb` pulse.
- R8: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`: 0 for control 0, 1 for control 1, 2 for reload. `wr_sel` = 3 changes nothing. Control 0 bit 7 and control 1 bits 7..1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_x2_boot | input | 1 | Power-up value of the global double-speed bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control 0, 1 control 1, 2 reload, 3 none |
| wr_data | input | 8 | Write data |
| cpu_en | output | 1 | Machine-cycle enable pulse |
| per_en | output | 7 | Peripheral enable pulses, mapping as in R4 |
| ale_stb | output | 1 | Address-latch strobe |

## Verification
The bench measures pulse spacing at the ports and compares it with periods computed from the requirements. It does this for fixed corner settings and for random settings.

One corner sets every per-peripheral bit while double speed is off. A design that fails to gate the overrides would produce 6-tick peripherals there. Another corner sets the overrides in mixed patterns. A swapped bit position would move the 12-tick period onto the wrong enable.

The bench covers reload FFh, FEh and 00h. An off-by-one in the divide-by-2×(255−N) stage would stretch or shrink every period. It also covers the unused register bits and the null select, where a decoder leak would change a period.

Finally, the bench switches speed mid-run and records each interval. A design that applied changes immediately would produce a short or odd interval.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  localparam int RELOAD_W = 8;                 // prescaler reload width
  localparam int NPER     = 7;                 // peripheral enables
  localparam int DIV_W    = RELOAD_W + 2;      // holds 2*(2^RELOAD_W-1)

  typedef struct packed {
    logic                x2;                   // global double speed
    logic [NPER-1:0]     slow;                 // per-peripheral 12-period override
    logic [RELOAD_W-1:0] reload;
  } mcg_cfg_t;

  // oscillator cycles per prescaled tick
  function automatic logic [DIV_W-1:0] presc_div(input logic [RELOAD_W-1:0] r);
    logic [DIV_W-1:0] gap;
    gap = {2'b00, ~r};                         // all-ones minus r
    return (&r) ? DIV_W'(1) : (gap << 1);
  endfunction

  // true on the last phase of each step-long slot inside the frame
  function automatic logic phase_hit(input int unsigned ph, input int unsigned step);
    return ((ph + 1) % step) == 0;
  endfunction
endpackage

// File: rtl/mcg_regs.sv
module mcg_regs
  import mcg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_x2_boot,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [7:0]     wr_data,
  input  logic           adopt,
  output mcg_cfg_t       act
);
  localparam logic [1:0] SEL_CTL0   = 2'd0;
  localparam logic [1:0] SEL_CTL1   = 2'd1;
  localparam logic [1:0] SEL_RELOAD = 2'd2;

  mcg_cfg_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend.x2     <= cfg_x2_boot;
      pend.slow   <= '0;
      pend.reload <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTL0: begin
          pend.x2            <= wr_data[0];
          pend.slow[NPER-1:1] <= wr_data[NPER-1:1];
        end
        SEL_CTL1:   pend.slow[0] <= wr_data[0];
        SEL_RELOAD: pend.reload  <= wr_data[RELOAD_W-1:0];
        default: ;
      endcase
    end
  end

  // active copy moves only at a machine-cycle boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act.x2     <= cfg_x2_boot;
      act.slow   <= '0;
      act.reload <= '1;
    end else if (adopt) begin
      act <= pend;
    end
  end
endmodule

// File: rtl/mcg_prescale.sv
module mcg_prescale #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  output logic          tick,
  output logic [DW-1:0] cnt
);
  assign tick = (cnt == div - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/mcg_phase.sv
module mcg_phase
  import mcg_pkg::*;
#(
  parameter int FULL = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  mcg_cfg_t        act,
  output logic            frame_end,
  output logic            cpu_en,
  output logic [NPER-1:0] per_en,
  output logic            ale_stb
);
  localparam int HALF  = FULL / 2;
  localparam int QUART = FULL / 4;
  localparam int PW    = $clog2(FULL);

  logic [PW-1:0] ph;
  logic on_full, on_half, on_quart;

  assign on_full   = phase_hit(32'(ph), FULL);
  assign on_half   = phase_hit(32'(ph), HALF);
  assign on_quart  = phase_hit(32'(ph), QUART);
  assign frame_end = tick && on_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ph <= '0;
    else if (frame_end) ph <= '0;
    else if (tick)      ph <= ph + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en  <= 1'b0;
      ale_stb <= 1'b0;
    end else begin
      cpu_en  <= tick && (act.x2 ? on_half  : on_full);
      ale_stb <= tick && (act.x2 ? on_quart : on_half);
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_per
    logic fast;
    assign fast = act.x2 && !act.slow[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_en[i] <= 1'b0;
      else        per_en[i] <= tick && (fast ? on_half : on_full);
    end
  end
endmodule

// File: rtl/mcg_top.sv
module mcg_top
  import mcg_pkg::*;
#(
  parameter int FRAME = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_x2_boot,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [7:0]      wr_data,
  output logic            cpu_en,
  output logic [NPER-1:0] per_en,
  output logic            ale_stb
);
  mcg_cfg_t         act_cfg;
  logic             frame_end;
  logic             pre_tick;
  logic [DIV_W-1:0] presc_div_w;
  logic [DIV_W-1:0] presc_cnt;

  assign presc_div_w = presc_div(act_cfg.reload);

  mcg_regs regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_x2_boot(cfg_x2_boot),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .adopt(frame_end), .act(act_cfg)
  );

  mcg_prescale #(.DW(DIV_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .div(presc_div_w),
    .tick(pre_tick), .cnt(presc_cnt)
  );

  mcg_phase #(.FULL(FRAME)) phase_i (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .act(act_cfg),
    .frame_end(frame_end), .cpu_en(cpu_en), .per_en(per_en), .ale_stb(ale_stb)
  );
endmodule

// File: rtl/mcg_checker.sv
module mcg_checker
  import mcg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_en,
  input logic [NPER-1:0]     per_en,
  input logic                ale_stb,
  input logic                frame_end,
  input logic                pre_tick,
  input logic                act_x2,
  input logic [RELOAD_W-1:0] act_reload,
  input logic [DIV_W-1:0]    presc_cnt,
  input logic [DIV_W-1:0]    presc_div_w
);
  // R7: enables are single-cycle pulses
  a_r7_cpu_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |=> !cpu_en);
  // R7: peripheral pulses land on machine-cycle pulses
  a_r7_per_on_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_en) |-> cpu_en);
  // R7: machine-cycle pulses land on address-latch pulses
  a_r7_cpu_on_ale: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> ale_stb);
  // R7: speed mode moves only after a frame end
  a_r7_x2_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_x2) |-> $past(frame_end));
  // R7: reload moves only after a frame end
  a_r7_reload_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_reload) |-> $past(frame_end));
  // R6: reload FFh means a tick every cycle
  a_r6_no_division: assert property (@(posedge clk) disable iff (!rst_n)
    (act_reload == '1) |-> pre_tick);
  // R6: prescaler count stays below its divisor
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    presc_cnt < presc_div_w);
endmodule

bind mcg_top mcg_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .per_en(per_en), .ale_stb(ale_stb),
  .frame_end(frame_end), .pre_tick(pre_tick), .act_x2(act_cfg.x2),
  .act_reload(act_cfg.reload), .presc_cnt(presc_cnt), .presc_div_w(presc_div_w)
);

// File: tb/mcg_top_tb_top.sv
module mcg_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_x2_boot = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic       cpu_en;
  logic [6:0] per_en;
  logic       ale_stb;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the register contents
  logic       m_x2;
  logic [7:0] m_ctl0, m_ctl1, m_reload;

  always #2.5 clk = ~clk;

  mcg_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_x2_boot(cfg_x2_boot),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_en(cpu_en), .per_en(per_en), .ale_stb(ale_stb)
  );

  function automatic int ticks_of(input logic [7:0] r);
    return (r == 8'd255) ? 1 : 2 * (255 - int'(r));
  endfunction

  // which: 0 cpu, 1..7 per_en[which-1], 8 address latch
  function automatic int exp_period(input int which);
    int d;
    logic slow;
    d = ticks_of(m_reload);
    if (which == 8) return d * (m_x2 ? 3 : 6);
    if (which == 0) return d * (m_x2 ? 6 : 12);
    slow = (which == 1) ? m_ctl1[0] : m_ctl0[which - 1];
    return d * ((m_x2 && !slow) ? 6 : 12);
  endfunction

  function automatic logic sig(input int which);
    if (which == 0) return cpu_en;
    if (which == 8) return ale_stb;
    return per_en[which - 1];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic get_interval(input int which, output int iv);
    int n = 0;
    while (!sig(which) && n < 8000) begin @(negedge clk); n++; end
    n = 1;
    @(negedge clk);
    while (!sig(which) && n < 8000) begin @(negedge clk); n++; end
    iv = n;
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_x2_boot = boot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_x2 = boot; m_ctl0 = {7'd0, boot}; m_ctl1 = 8'd0; m_reload = 8'hFF;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    int old_d;
    old_d = ticks_of(m_reload);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
    case (sel)
      2'd0: begin m_ctl0 = d; m_x2 = d[0]; end
      2'd1: m_ctl1 = d;
      2'd2: m_reload = d;
      default: ;
    endcase
    // settle past the next frame boundary
    repeat (36 * ((old_d > ticks_of(m_reload)) ? old_d : ticks_of(m_reload)) + 4)
      @(negedge clk);
  endtask

  task automatic check_all(input string req);
    int iv;
    for (int w = 0; w < 9; w++) begin
      get_interval(w, iv);
      check(req, iv, exp_period(w));
    end
  endtask

  initial begin
    int iv;
    logic [7:0] r0, r1, rr;
    void'($urandom(32'd20417));
    do_reset(1'b0);
    n_checks++;
    if (cpu_en !== 1'b0 || per_en !== 7'd0 || ale_stb !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: outputs after reset %b/%b/%b expected 0/0/0", cpu_en, per_en, ale_stb);
    end
    check_all("R1 reset normal speed");

    // R2: overrides all set, global bit clear -> ignored
    wr(2'd0, 8'hFE); wr(2'd1, 8'h01);
    check_all("R2 overrides ignored");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    check_all("R2 normal speed");

    // R3/R4 double speed, all overrides clear
    wr(2'd0, 8'h01);
    check_all("R3 double speed");
    check_all("R5 latch strobe");

    // R4 mixed overrides: watchdog, UART, timer 1 slow
    wr(2'd0, 8'h55);
    check_all("R4 mixed overrides");
    wr(2'd0, 8'h2B); wr(2'd1, 8'h01);
    check_all("R4 other overrides");

    // R8: null select and unused bits
    wr(2'd3, 8'h00);
    check_all("R8 null select");
    wr(2'd1, 8'hFE);
    check_all("R8 ctl1 upper bits");
    wr(2'd0, 8'h81);
    check_all("R8 ctl0 bit7");

    // R6 prescaler corners
    wr(2'd2, 8'hFE);
    check_all("R6 reload FEh");
    wr(2'd2, 8'h00);
    get_interval(0, iv);
    check("R6 reload 00h", iv, exp_period(0));
    wr(2'd2, 8'hFF);
    check_all("R6 reload FFh");

    // R7: speed change mid-run, every interval old or new period
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
    for (int k = 0; k < 6; k++) begin
      get_interval(0, iv);
      check("R7 no truncated cycle", (iv == 6 || iv == 12) ? 1 : 0, 1);
    end
    m_ctl0 = 8'h00; m_x2 = 1'b0;
    repeat (40) @(negedge clk);
    check_all("R7 after change");

    // random configurations
    for (int k = 0; k < 8; k++) begin
      r0 = 8'($urandom);
      r1 = 8'($urandom);
      rr = ($urandom % 3 == 0) ? 8'hFF : 8'(240 + $urandom % 15);
      wr(2'd0, r0); wr(2'd1, r1); wr(2'd2, rr);
      check_all("R4/R6 random setting");
    end

    // R1 with double speed at power-up
    do_reset(1'b1);
    check_all("R1 reset double speed");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule